// File: doc/BRIEF.md
# Eight-Output Addressable Latch and Demultiplexer

This block keeps eight single-bit storage cells that are filled one at a time from a single data input, with a 3-bit address choosing the cell. Two active-low controls, `clr_n` and `en_n`, put the block in one of four modes. It can write the data bit into the addressed cell, hold all cells, act as a 1-of-8 demultiplexer whose unaddressed outputs are driven low, or force every output low. When the data input is tied high in demultiplexer mode, the block works as a 1-of-8 decoder with active-high outputs.

The latch is modelled with a system clock. In write mode the addressed output follows the data input with no delay, and the storage cell captures that value at each rising clock edge. `clr_n` empties the storage asynchronously. A synchronous active-low reset `rst_n` also empties the storage. The address should only change while `en_n` is high, so that no cell is written by accident.

Top module: `addr_latch8`

## Requirements
- R1: Mode encoding, with both controls active low: clr_n=1 and en_n=0 is write mode; clr_n=1 and en_n=1 is hold mode; clr_n=0 and en_n=0 is demultiplexer mode; clr_n=0 and en_n=1 is clear mode. In write mode, output bit `addr` equals `din` in the same cycle.
- R2: In write mode, every output bit other than bit `addr` shows the value that bit stored before.
- R3: The value of `din` at a rising clock edge in write mode is stored in cell `addr`. That value is still shown after the block moves to hold mode.
- R4: In hold mode, `q` shows the stored cells and does not depend on `din` or `addr`.
- R5: In demultiplexer mode, `q[addr]` equals `din` and all other bits are 0. With `din`=1, `q` is one-hot.
- R6: In clear mode, `q` is all zeros for any `addr` and `din`.
- R7: While `clr_n` is low, all stored cells are emptied without waiting for a clock edge. After demultiplexer or clear mode, hold mode shows all zeros.
- R8: A rising clock edge with `rst_n` low empties all stored cells.
- R9: Address value k (0 to 7) selects output bit k in the write and demultiplexer modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; storage cells update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the storage |
| clr_n | input | 1 | Active-low clear/mode control; empties storage asynchronously |
| en_n | input | 1 | Active-low enable/mode control |
| addr | input | 3 | Selects the cell or output bit |
| din | input | 1 | Data bit to write or to route |
| q | output | 8 | Parallel outputs |

## Verification
All outputs are combinational functions of the current inputs and the stored cells. A change on `din`, `addr`, `en_n` or `clr_n` therefore appears on `q` in the same cycle. A written value becomes part of the stored state only at the next rising edge, so it can be seen one cycle later in hold mode. The bench drives inputs on the falling edge and compares `q` 1 ns later, before the next rising edge. Its reference model of the cells updates only after each rising edge, and it is emptied at once whenever `clr_n` is driven low.

// File: rtl/addr_latch8_pkg.sv
// Package: shared mode type and sizing for the addressable latch.
// Assumes the width is a power of two so the address covers every bit.
package addr_latch8_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } alat_mode_e;
endpackage

// File: rtl/alat_mode_dec.sv
// Module: turns the two active-low controls into one of four modes.
// Assumes the controls are already synchronous with the system clock.
module alat_mode_dec
    import addr_latch8_pkg::*;
(
    input  logic       clr_n,
    input  logic       en_n,
    output alat_mode_e mode
);
    // Purpose: map the control pair onto the mode enumeration.
    always_comb begin
        unique case ({clr_n, en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/alat_store.sv
// Module: the bank of storage cells, one flop per output bit.
// Assumes clr_n is free of glitches; it clears the cells asynchronously.
module alat_store #(
    parameter int N_BITS = 8,
    localparam int AW    = $clog2(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic              din,
    output logic [N_BITS-1:0] cells
);
    for (genvar i = 0; i < N_BITS; i++) begin : g_cell
        // Purpose: capture din into cell i when it is addressed in write mode.
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)
                cells[i] <= 1'b0;
            else if (!rst_n)
                cells[i] <= 1'b0;
            else if (wr_en && (addr == AW'(i)))
                cells[i] <= din;
        end
    end
endmodule

// File: rtl/alat_outsel.sv
// Module: builds each output bit from the mode, the address hit and the cells.
// Assumes purely combinational use; q follows its inputs in the same cycle.
module alat_outsel
    import addr_latch8_pkg::*;
#(
    parameter int N_BITS = 8,
    localparam int AW    = $clog2(N_BITS)
) (
    input  alat_mode_e        mode,
    input  logic [AW-1:0]     addr,
    input  logic              din,
    input  logic [N_BITS-1:0] cells,
    output logic [N_BITS-1:0] q
);
    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        logic hit;
        assign hit = (addr == AW'(i));
        // Purpose: choose what bit i shows for the current mode.
        always_comb begin
            unique case (mode)
                MODE_WRITE: q[i] = hit ? din : cells[i];
                MODE_HOLD:  q[i] = cells[i];
                MODE_DEMUX: q[i] = hit & din;
                default:    q[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/addr_latch8.sv
// Module: top of the eight-output addressable latch and demultiplexer.
// Assumes the address changes only while en_n is high (no stray writes).
module addr_latch8
    import addr_latch8_pkg::*;
#(
    parameter int N_BITS = 8,
    localparam int AW    = $clog2(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              en_n,
    input  logic [AW-1:0]     addr,
    input  logic              din,
    output logic [N_BITS-1:0] q
);
    alat_mode_e        mode;
    logic [N_BITS-1:0] cells;

    alat_mode_dec u_dec (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    alat_store #(.N_BITS(N_BITS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .wr_en (mode == MODE_WRITE),
        .addr  (addr),
        .din   (din),
        .cells (cells)
    );

    alat_outsel #(.N_BITS(N_BITS)) u_out (
        .mode  (mode),
        .addr  (addr),
        .din   (din),
        .cells (cells),
        .q     (q)
    );
endmodule

// File: rtl/addr_latch8_chk.sv
// Module: property checker bound to addr_latch8; observes ports only.
module addr_latch8_chk #(
    parameter int N_BITS = 8,
    localparam int AW    = $clog2(N_BITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              en_n,
    input logic [AW-1:0]     addr,
    input logic              din,
    input logic [N_BITS-1:0] q
);
    // R6: clear mode drives every output low
    p_clear_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && en_n) |-> (q == '0));

    // R5: demultiplexer routes din to one bit only
    p_demux_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |-> (q[addr] == din && $countones(q) <= 1));

    // R1: write mode passes din through to the addressed bit
    p_write_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |-> (q[addr] == din));

    // R4: hold mode keeps q steady across cycles
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n && $past(rst_n) && $past(clr_n && en_n)) |-> $stable(q));

    // R3: the written value survives entry into hold mode
    p_write_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n && $past(rst_n && clr_n && !en_n)) |-> (q[$past(addr)] == $past(din)));

    // R7: after any cycle with clr_n low, hold mode shows zeros
    p_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n && $past(rst_n) && $past(!clr_n)) |-> (q == '0));
endmodule

bind addr_latch8 addr_latch8_chk #(.N_BITS(N_BITS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n),
    .en_n  (en_n),
    .addr  (addr),
    .din   (din),
    .q     (q)
);

// File: tb/addr_latch8_tb.sv
`timescale 1ns/1ps
module addr_latch8_tb;
    logic       clk = 1'b0;
    logic       rst_n, clr_n, en_n, din;
    logic [2:0] addr;
    logic [7:0] q;
    logic [7:0] model;
    int         n_chk = 0;
    int         n_fail = 0;
    int unsigned seed = 32'd20240611;

    always #2 clk = ~clk;

    addr_latch8 u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
        .addr(addr), .din(din), .q(q)
    );

    // Expected outputs from the requirement rules
    function automatic logic [7:0] exp_q(input logic c, input logic g,
                                         input logic [2:0] a, input logic d,
                                         input logic [7:0] m);
        logic [7:0] r;
        case ({c, g})
            2'b10: begin r = m; r[a] = d; end
            2'b11: r = m;
            2'b00: begin r = '0; r[a] = d; end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected=%b (clr_n=%b en_n=%b addr=%0d din=%b)",
                     req, q, exp, clr_n, en_n, addr, din);
        end
    endtask

    // Drive on falling edge, check 1 ns later, advance model after rising edge
    task automatic step(input logic c, input logic g, input logic [2:0] a,
                        input logic d, input string req);
        @(negedge clk);
        clr_n = c; en_n = g; addr = a; din = d;
        if (!c) model = '0;
        #1 check(req, exp_q(c, g, a, d, model));
        @(posedge clk);
        if (!clr_n) model = '0;
        else if (!rst_n) model = '0;
        else if (!en_n) model[addr] = din;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr_n = 1'b1; en_n = 1'b1; addr = '0; din = 1'b0;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 check("R8 reset state", 8'h00);

        // R9 / R3: write each address, then read in hold mode
        for (int k = 0; k < 8; k++) step(1, 0, 3'(k), k[0], "R9 write addr");
        step(1, 1, 3'd5, 1'b1, "R3 hold after writes");
        step(1, 1, 3'd2, 1'b0, "R4 hold ignores din/addr");
        // R2: overwrite one bit; others keep their values
        step(1, 0, 3'd3, 1'b0, "R2 write one bit");
        step(1, 1, 3'd0, 1'b1, "R3 kept value");
        // R5: decoder with din=1 at every address, then din=0
        for (int k = 0; k < 8; k++) step(0, 0, 3'(k), 1'b1, "R5 decoder one-hot");
        step(0, 0, 3'd4, 1'b0, "R5 demux din=0");
        step(1, 1, 3'd4, 1'b1, "R7 hold after demux");
        // R6: clear mode over all addresses and data
        for (int k = 0; k < 8; k++) step(1, 0, 3'(k), 1'b1, "R1 refill");
        for (int k = 0; k < 8; k++) step(0, 1, 3'(k), k[1], "R6 clear mode");
        step(1, 1, 3'd7, 1'b1, "R7 hold after clear");
        // R8: synchronous reset empties written cells
        step(1, 0, 3'd6, 1'b1, "R1 write before reset");
        @(negedge clk); rst_n = 1'b0; clr_n = 1'b1; en_n = 1'b1;
        @(posedge clk); model = '0;
        @(negedge clk); rst_n = 1'b1;
        #1 check("R8 after reset", 8'h00);

        // Constrained random mix of all four modes
        for (int n = 0; n < 600; n++) begin
            int unsigned r;
            logic c, g;
            r = $urandom(seed) % 10;
            seed = seed + 32'd7919;
            c = (r > 1);
            g = (r > 5) || (r == 1);
            step(c, g, 3'($urandom(seed + 1) % 8), 1'($urandom(seed + 2) % 2), "R1-mix random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule